// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block keeps the configuration word of a clock synthesizer: a 9-bit feedback divide value, two 3-bit output divide codes (bank A and bank B) and a 2-bit test selector. The word is written either from parallel pins under a parallel-load strobe or from a 17-bit serial frame. The frame arrives on a slow serial clock, data and load interface. All strobes, the serial clock and the serial data are brought into a fast system clock domain through synchronizer flops. Edges are then detected on the synchronized copies.

A test pin is also driven here. The test selector picks one of four sources for it: a constant low, the head bit of the shift register, the feedback divider output, or the bank-A output clock. The pin is held low while parallel mode is active or master reset is high. Master reset never touches the stored word. After system reset the parallel pins drive the word until the first parallel latch or serial transfer. Hardwired pins therefore set the default configuration.

Top module: `synth_cfg_loader`

## Requirements
- R1: While the synchronized parallel strobe is high, each synchronized rising edge of the serial clock shifts the serial data bit into a 17-bit shift register. After 17 shifts the first bit sent sits at bit 16. The frame layout is test selector in bits 16:15 (sent first), bank-B code in 14:12, bank-A code in 11:9 and feedback value in 8:0 (sent last, LSB at bit 0).
- R2: A rising edge of the serial load copies the whole shift register into the stored word, test selector included.
- R3: After the serial load falls, the stored word holds. Further serial shifts with the load low leave it unchanged.
- R4: While the serial load is high, every serial shift also copies the new shift register contents into the stored word.
- R5: While the parallel strobe is low, the feedback and both output divide fields follow the parallel pins. The test selector keeps its value.
- R6: A rising edge of the parallel strobe latches the pins. Later pin changes are ignored until the strobe goes low again or a serial transfer occurs.
- R7: After system reset the divide fields follow the parallel pins until the first parallel latch or serial transfer.
- R8: The test pin follows the test selector: 00 drives low, 01 drives shift register bit 16, 10 drives the feedback divider input, and 11 drives the bank-A clock input.
- R9: The test pin is low whenever the synchronized parallel strobe is low.
- R10: While master reset is high the test pin is low, and the stored word keeps its value.
- R11: System reset clears the test selector to 00, so the test pin reads low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| arst_n | input | 1 | Asynchronous active-low system reset |
| pin_m | input | 9 | Parallel feedback divide value |
| pin_na | input | 3 | Parallel bank-A divide code |
| pin_nb | input | 3 | Parallel bank-B divide code |
| pload_n | input | 1 | Parallel strobe: low = follow pins, rising = latch |
| sclk | input | 1 | Serial shift clock |
| sdat | input | 1 | Serial data |
| sload | input | 1 | Serial load strobe |
| mreset | input | 1 | Master reset: forces the test pin low, keeps the word |
| fbdiv_in | input | 1 | Feedback divider output, test source 10 |
| banka_clk | input | 1 | Bank-A output clock, test source 11 |
| cfg_m | output | 9 | Stored feedback divide value |
| cfg_na | output | 3 | Stored bank-A code |
| cfg_nb | output | 3 | Stored bank-B code |
| cfg_t | output | 2 | Stored test selector |
| test_out | output | 1 | Test pin |

## Verification
Random 17-bit frames with random selectors exercise the shift order and field boundaries. A swapped bit or a misplaced field shows as a wrong field value. Frames with each fixed selector are combined with toggled feedback and bank-A levels, which separates the four test sources. A held serial load followed by extra shifts distinguishes pass-through copying from transfer on the load edge and from holding after the fall. Pin changes before and after the parallel latch, and after reset, separate following from latching. Master reset is applied over a loaded word to show the word is kept while the pin drops.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  localparam int unsigned CFGL_M_W   = 9;
  localparam int unsigned CFGL_N_W   = 3;
  localparam int unsigned CFGL_T_W   = 2;
  localparam int unsigned CFGL_SYNC  = 2;

  typedef enum logic [1:0] {
    TSEL_LOW   = 2'b00,
    TSEL_SHIFT = 2'b01,
    TSEL_FBDIV = 2'b10,
    TSEL_BANKA = 2'b11
  } tsel_e;
endpackage

// File: rtl/cfgl_rst_sync.sv
module cfgl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[g] <= '0;
          else        pipe_q[g] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[g] <= '0;
          else        pipe_q[g] <= pipe_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/cfgl_edge.sv
module cfgl_edge #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);
  localparam int unsigned WARM = STAGES + 1;
  localparam int unsigned CW   = $clog2(WARM + 1);

  logic [W-1:0]  prev_q;
  logic [CW-1:0] warm_q, warm_d;
  logic          primed;

  assign primed = (warm_q == CW'(WARM));

  always_comb begin
    warm_d = warm_q;
    if (!primed) warm_d = warm_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      warm_q <= '0;
    end else begin
      prev_q <= din;
      warm_q <= warm_d;
    end
  end

  assign rise = primed ? (din & ~prev_q) : '0;
endmodule

// File: rtl/cfgl_shifter.sv
module cfgl_shifter #(
  parameter int unsigned FRAME_W = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               din,
  output logic [FRAME_W-1:0] sr_q,
  output logic [FRAME_W-1:0] sr_next
);
  always_comb begin
    sr_next = sr_q;
    if (shift_en) sr_next = {sr_q[FRAME_W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_next;
  end
endmodule

// File: rtl/cfgl_word_reg.sv
module cfgl_word_reg #(
  parameter int unsigned FRAME_W = 17,
  parameter int unsigned MNN_W   = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MNN_W-1:0]   pins_mnn,
  input  logic               par_low,
  input  logic               par_rise,
  input  logic               ld_level,
  input  logic               ld_rise,
  input  logic               shift_evt,
  input  logic [FRAME_W-1:0] sr_q,
  input  logic [FRAME_W-1:0] sr_next,
  output logic [FRAME_W-1:0] word_q,
  output logic               follow_q
);
  logic [FRAME_W-1:0] word_d;
  logic               follow_d;
  logic               pass_thru;

  assign pass_thru = ld_level & shift_evt;

  always_comb begin
    word_d   = word_q;
    follow_d = follow_q;
    if (par_low) begin
      word_d[MNN_W-1:0] = pins_mnn;
    end else if (pass_thru) begin
      word_d   = sr_next;
      follow_d = 1'b0;
    end else if (ld_rise) begin
      word_d   = sr_q;
      follow_d = 1'b0;
    end else if (par_rise) begin
      word_d[MNN_W-1:0] = pins_mnn;
      follow_d          = 1'b0;
    end else if (follow_q) begin
      word_d[MNN_W-1:0] = pins_mnn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      follow_q <= 1'b1;
    end else begin
      word_q   <= word_d;
      follow_q <= follow_d;
    end
  end
endmodule

// File: rtl/cfgl_test_mux.sv
module cfgl_test_mux (
  input  logic [1:0] tsel,
  input  logic       force_low,
  input  logic       sr_head,
  input  logic       fbdiv,
  input  logic       banka,
  output logic       test_o
);
  import cfgl_pkg::*;

  always_comb begin
    unique case (tsel_e'(tsel))
      TSEL_LOW:   test_o = 1'b0;
      TSEL_SHIFT: test_o = sr_head;
      TSEL_FBDIV: test_o = fbdiv;
      TSEL_BANKA: test_o = banka;
      default:    test_o = 1'b0;
    endcase
    if (force_low) test_o = 1'b0;
  end
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader #(
  parameter int unsigned M_W         = cfgl_pkg::CFGL_M_W,
  parameter int unsigned N_W         = cfgl_pkg::CFGL_N_W,
  parameter int unsigned SYNC_STAGES = cfgl_pkg::CFGL_SYNC
) (
  input  logic           clk,
  input  logic           arst_n,
  input  logic [M_W-1:0] pin_m,
  input  logic [N_W-1:0] pin_na,
  input  logic [N_W-1:0] pin_nb,
  input  logic           pload_n,
  input  logic           sclk,
  input  logic           sdat,
  input  logic           sload,
  input  logic           mreset,
  input  logic           fbdiv_in,
  input  logic           banka_clk,
  output logic [M_W-1:0] cfg_m,
  output logic [N_W-1:0] cfg_na,
  output logic [N_W-1:0] cfg_nb,
  output logic [1:0]     cfg_t,
  output logic           test_out
);
  localparam int unsigned T_W     = cfgl_pkg::CFGL_T_W;
  localparam int unsigned MNN_W   = M_W + 2 * N_W;
  localparam int unsigned FRAME_W = T_W + MNN_W;

  logic               rst_n_s;
  logic               par_s, sclk_s, ld_s, dat_s;
  logic               par_rise, sclk_rise, ld_rise;
  logic               shift_evt;
  logic [FRAME_W-1:0] sr_q, sr_next, word_q;
  logic               follow_q;
  logic [MNN_W-1:0]   pins_mnn;

  cfgl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_n_o(rst_n_s)
  );

  cfgl_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s),
    .din({pload_n, sclk, sload, sdat}),
    .dout({par_s, sclk_s, ld_s, dat_s})
  );

  cfgl_edge #(.W(3), .STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n_s),
    .din({par_s, sclk_s, ld_s}),
    .rise({par_rise, sclk_rise, ld_rise})
  );

  assign shift_evt = sclk_rise & par_s;
  assign pins_mnn  = {pin_nb, pin_na, pin_m};

  cfgl_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n_s), .shift_en(shift_evt), .din(dat_s),
    .sr_q(sr_q), .sr_next(sr_next)
  );

  cfgl_word_reg #(.FRAME_W(FRAME_W), .MNN_W(MNN_W)) u_word (
    .clk(clk), .rst_n(rst_n_s), .pins_mnn(pins_mnn),
    .par_low(~par_s), .par_rise(par_rise), .ld_level(ld_s),
    .ld_rise(ld_rise), .shift_evt(shift_evt),
    .sr_q(sr_q), .sr_next(sr_next),
    .word_q(word_q), .follow_q(follow_q)
  );

  cfgl_test_mux u_tmux (
    .tsel(word_q[FRAME_W-1 -: T_W]),
    .force_low(~par_s | mreset),
    .sr_head(sr_q[FRAME_W-1]),
    .fbdiv(fbdiv_in),
    .banka(banka_clk),
    .test_o(test_out)
  );

  assign cfg_m  = word_q[M_W-1:0];
  assign cfg_na = word_q[M_W +: N_W];
  assign cfg_nb = word_q[M_W+N_W +: N_W];
  assign cfg_t  = word_q[FRAME_W-1 -: T_W];
endmodule

// File: rtl/cfgl_checker.sv
module cfgl_checker #(
  parameter int unsigned FRAME_W = 17,
  parameter int unsigned MNN_W   = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic               par_s,
  input logic               ld_s,
  input logic               ld_rise,
  input logic               par_rise,
  input logic               shift_evt,
  input logic               follow_q,
  input logic [FRAME_W-1:0] sr_q,
  input logic [FRAME_W-1:0] word_q,
  input logic [MNN_W-1:0]   pins_mnn,
  input logic               mreset,
  input logic               test_out
);
  p_par_test_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !par_s |-> !test_out);

  p_mreset_test_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mreset |-> !test_out);

  p_par_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !par_s |=> word_q[MNN_W-1:0] == $past(pins_mnn));

  p_par_keeps_tsel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !par_s |=> word_q[FRAME_W-1:MNN_W] == $past(word_q[FRAME_W-1:MNN_W]));

  p_load_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (par_s && ld_rise && !shift_evt) |=> word_q == $past(sr_q));

  p_pass_thru_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (par_s && ld_s && shift_evt) |=> word_q == sr_q);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (par_s && !follow_q && !ld_rise && !par_rise && !(ld_s && shift_evt))
      |=> $stable(word_q));
endmodule

bind synth_cfg_loader cfgl_checker #(.FRAME_W(FRAME_W), .MNN_W(MNN_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .par_s(par_s), .ld_s(ld_s),
  .ld_rise(ld_rise), .par_rise(par_rise), .shift_evt(shift_evt),
  .follow_q(follow_q), .sr_q(sr_q), .word_q(word_q),
  .pins_mnn(pins_mnn), .mreset(mreset), .test_out(test_out)
);

// File: tb/synth_cfg_loader_bench.sv
module synth_cfg_loader_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       arst_n;
  logic [8:0] pin_m;
  logic [2:0] pin_na, pin_nb;
  logic       pload_n, sclk, sdat, sload, mreset, fbdiv_in, banka_clk;
  logic [8:0] cfg_m;
  logic [2:0] cfg_na, cfg_nb;
  logic [1:0] cfg_t;
  logic       test_out;

  always #(CLK_P/2) clk = ~clk;

  synth_cfg_loader u_synth_cfg_loader (
    .clk(clk), .arst_n(arst_n), .pin_m(pin_m), .pin_na(pin_na), .pin_nb(pin_nb),
    .pload_n(pload_n), .sclk(sclk), .sdat(sdat), .sload(sload), .mreset(mreset),
    .fbdiv_in(fbdiv_in), .banka_clk(banka_clk), .cfg_m(cfg_m), .cfg_na(cfg_na),
    .cfg_nb(cfg_nb), .cfg_t(cfg_t), .test_out(test_out)
  );

  typedef struct {
    string       tag;
    logic [16:0] word;
    logic        tst;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 0;

  logic [16:0] mcfg, msr;
  bit          mfollow;

  function automatic logic exp_test();
    if (!pload_n || mreset) return 1'b0;
    case (mcfg[16:15])
      2'b00:   return 1'b0;
      2'b01:   return msr[16];
      2'b10:   return fbdiv_in;
      default: return banka_clk;
    endcase
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_now(string tag);
    exp_t e;
    tick(10);
    e.tag  = tag;
    e.word = mcfg;
    e.tst  = exp_test();
    q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic set_pins(logic [8:0] m, logic [2:0] na, logic [2:0] nb);
    pin_m = m; pin_na = na; pin_nb = nb;
    if (!pload_n || mfollow) mcfg[14:0] = {nb, na, m};
  endtask

  task automatic shift_bit(logic b);
    sdat = b;
    tick(4);
    sclk = 1'b1;
    tick(4);
    sclk = 1'b0;
    tick(4);
    msr = {msr[15:0], b};
    if (sload) begin mcfg = msr; mfollow = 0; end
  endtask

  task automatic load_frame(logic [16:0] f);
    for (int i = 16; i >= 0; i--) shift_bit(f[i]);
    sload = 1'b1;
    mcfg = msr; mfollow = 0;
    tick(8);
    sload = 1'b0;
    tick(8);
  endtask

  // monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        logic [16:0] act;
        e   = q.pop_front();
        act = {cfg_t, cfg_nb, cfg_na, cfg_m};
        n_chk++;
        if (act !== e.word || test_out !== e.tst) begin
          n_err++;
          $display("FAIL %s: word=%h test=%b expected word=%h test=%b",
                   e.tag, act, test_out, e.word, e.tst);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    arst_n = 0; pload_n = 1; sclk = 0; sdat = 0; sload = 0; mreset = 0;
    fbdiv_in = 0; banka_clk = 0;
    pin_m = 9'd27; pin_na = 3'd3; pin_nb = 3'd5;
    mcfg = {2'b00, 3'd5, 3'd3, 9'd27}; msr = '0; mfollow = 1;
    tick(10);
    arst_n = 1;
    expect_now("R11 reset state, R7 pins drive default");
    set_pins(9'd23, 3'd1, 3'd7);
    expect_now("R7 pins still followed before any latch");

    pload_n = 0; mcfg[14:0] = {pin_nb, pin_na, pin_m};
    set_pins(9'd30, 3'd6, 3'd2);
    expect_now("R5 R9 parallel follow, test low");
    pload_n = 1; mfollow = 0;
    tick(10);
    set_pins(9'd100, 3'd0, 3'd4);
    expect_now("R6 latched pins ignore changes");

    for (int k = 0; k < 4; k++) begin
      logic [16:0] f;
      f = 17'($urandom);
      load_frame(f);
      expect_now("R1 R2 random frame fields");
    end
    for (int k = 0; k < 5; k++) shift_bit(1'(k));
    expect_now("R3 shifts with load low keep word");

    fbdiv_in = 1; banka_clk = 0;
    load_frame({2'b00, 3'd2, 3'd4, 9'h155});
    expect_now("R8 selector 00 low");
    load_frame({2'b01, 3'd1, 3'd1, 9'h0AA});
    shift_bit(1'b1);
    expect_now("R8 selector 01 shift head");
    for (int k = 0; k < 15; k++) shift_bit(1'b1);
    expect_now("R8 selector 01 shift head after more shifts");
    load_frame({2'b10, 3'd3, 3'd6, 9'h1FF});
    expect_now("R8 selector 10 feedback high");
    fbdiv_in = 0;
    expect_now("R8 selector 10 feedback low");
    load_frame({2'b11, 3'd7, 3'd0, 9'h001});
    banka_clk = 1;
    expect_now("R8 selector 11 bank A high");
    banka_clk = 0;
    expect_now("R8 selector 11 bank A low");

    sload = 1; mcfg = msr; mfollow = 0;
    tick(8);
    for (int k = 0; k < 3; k++) begin
      shift_bit(k != 1);
      expect_now("R4 pass-through on each shift");
    end
    sload = 0;
    tick(8);
    shift_bit(1'b0); shift_bit(1'b1);
    expect_now("R3 hold after load fall");

    load_frame({2'b11, 3'd4, 3'd2, 9'd28});
    banka_clk = 1;
    mreset = 1;
    expect_now("R10 master reset keeps word, test low");
    mreset = 0;
    expect_now("R10 master reset released, bank A visible");

    pload_n = 0; mcfg[14:0] = {pin_nb, pin_na, pin_m};
    set_pins(9'd18, 3'd5, 3'd1);
    expect_now("R9 R5 parallel mode test low, selector kept");
    pload_n = 1; mfollow = 0;
    tick(10);
    set_pins(9'd62, 3'd2, 3'd3);
    expect_now("R6 second latch holds");

    tick(5);
    while (q.size() != 0) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule